// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

This block is a register-mapped mailbox that lets one processor signal another. It has three separate channels, and each channel holds a 32-bit pending word. A sender raises doorbell bits by writing ones to the channel's set register. The receiver acknowledges them by writing ones to the channel's clear register. Both sides can read the pending word at any time. A zero in either write leaves the matching bit unchanged. The only sign that a message was consumed is the receiver clearing its bits, so senders poll the pending word until it drops.

Each channel drives one active-high interrupt toward the receiver. The interrupt comes from a register that holds the OR of the channel's 32 pending bits. Channel 0 carries low-priority traffic and channel 1 carries high-priority traffic. Channel 2 is reserved for secure software: a non-secure APB transaction to that channel is refused with an error response, and the refused access changes nothing and reads nothing.

The block is an APB slave with no wait states and runs on the APB clock. Its reset is asynchronous and active-low.

Top module: `mbx_doorbell_top`

## Requirements
- R1: After reset every pending word reads zero, every interrupt is low, and PSLVERR is low.
- R2: A write to offset 0x08 of a channel window sets each pending bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R3: A write to offset 0x10 of a channel window clears each pending bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R4: A read of offset 0x00 of a channel window returns that channel's pending word, and the value includes a write completed in an earlier transfer.
- R5: A channel's interrupt goes high one clock after the transfer that makes its pending word non-zero. It goes low one clock after the transfer that makes the word zero.
- R6: The channel windows are 0x20 bytes apart: channel 0 at 0x000, channel 1 at 0x020 and channel 2 at 0x040. A write to one channel changes no other channel's pending word or interrupt.
- R7: An access to channel 2 with PPROT[1]=1 (non-secure) returns PSLVERR=1 in its access phase. A read returns zero, and a write changes neither the pending word nor the interrupt.
- R8: An access to channel 2 with PPROT[1]=0 (secure) behaves like an access to any other channel, and PSLVERR stays 0.
- R9: Reads of offsets 0x08 and 0x10, and reads of unmapped addresses, return zero without an error. Writes to offset 0x00 and to unmapped addresses change no pending word.
- R10: PREADY is always 1, so every transfer completes in its first access-phase cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| pprot | input | 3 | Protection; bit 1 set means non-secure |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete, tied high |
| pslverr | output | 1 | Error response for a refused secure-channel access |
| irq | output | 3 | Per-channel interrupt, bit n for channel n |

## Verification
The assertions assume well-formed APB transfers. Each access phase follows a setup phase with the same address, direction and data, and PSEL never drops within a transfer. The bench drives every transfer through one task that raises PSEL, then PENABLE on the next falling edge, and returns both to idle afterwards, so the inputs never break this protocol. Because one APB port issues at most one write per cycle, the set-over-clear priority in the pending-word update cannot be reached from the ports. It is therefore held in a package function and not tested as a requirement.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_DATA_W = 32;
  localparam logic [4:0] OFF_STATUS = 5'h00;
  localparam logic [4:0] OFF_SET    = 5'h08;
  localparam logic [4:0] OFF_CLEAR  = 5'h10;

  // New pending word: clear first, then set, so a set wins over a clear on the same bit.
  function automatic logic [MBX_DATA_W-1:0] pending_next(
    input logic [MBX_DATA_W-1:0] cur,
    input logic [MBX_DATA_W-1:0] set_mask,
    input logic [MBX_DATA_W-1:0] clr_mask);
    return (cur & ~clr_mask) | set_mask;
  endfunction
endpackage

// File: rtl/mbx_apb_decode.sv
module mbx_apb_decode #(
  parameter int NUM_CH    = 3,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int WIN_BITS  = 5,
  parameter int SECURE_CH = 2
) (
  input  logic                     pclk,
  input  logic                     presetn,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [ADDR_W-1:0]        paddr,
  input  logic [2:0]               pprot,
  input  logic [NUM_CH*DATA_W-1:0] pend_flat,
  output logic [NUM_CH-1:0]        set_en,
  output logic [NUM_CH-1:0]        clr_en,
  output logic [DATA_W-1:0]        rdata,
  output logic                     slverr
);
  import mbx_pkg::*;
  localparam int WIN_W = ADDR_W - WIN_BITS;

  logic              access;
  logic [WIN_W-1:0]  win_idx;
  logic [4:0]        win_off;
  logic [NUM_CH-1:0] hit, refused, granted;

  assign access  = psel & penable;
  assign win_idx = paddr[ADDR_W-1:WIN_BITS];
  assign win_off = 5'(paddr[WIN_BITS-1:0]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_win
    assign hit[c]     = (win_idx == WIN_W'(c));
    assign refused[c] = (c == SECURE_CH) && pprot[1];
    assign granted[c] = access & hit[c] & ~refused[c];
    assign set_en[c]  = granted[c] & pwrite & (win_off == OFF_SET);
    assign clr_en[c]  = granted[c] & pwrite & (win_off == OFF_CLEAR);
  end

  assign slverr = access & |(hit & refused);

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (granted[c] && !pwrite && win_off == OFF_STATUS)
        rdata = pend_flat[c*DATA_W +: DATA_W];
    end
  end

  AST_ERR_IN_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
    slverr |-> (psel && penable)); // R7
  AST_ERR_NO_DATA: assert property (@(posedge pclk) disable iff (!presetn)
    slverr |-> (rdata == '0)); // R7
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int DATA_W = 32
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] pending,
  output logic              irq
);
  import mbx_pkg::*;

  logic [DATA_W-1:0] set_mask, clr_mask;
  assign set_mask = set_en ? wdata : '0;
  assign clr_mask = clr_en ? wdata : '0;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      pending <= '0;
      irq     <= 1'b0;
    end else begin
      pending <= pending_next(pending, set_mask, clr_mask);
      irq     <= |pending;
    end
  end

  AST_SET_TAKES: assert property (@(posedge pclk) disable iff (!presetn)
    set_en |=> ((pending & $past(wdata)) == $past(wdata))); // R2
  AST_CLR_TAKES: assert property (@(posedge pclk) disable iff (!presetn)
    (clr_en && !set_en) |=> ((pending & $past(wdata)) == '0)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge pclk) disable iff (!presetn)
    (!set_en && !clr_en) |=> $stable(pending)); // R9
  AST_IRQ_RISE: assert property (@(posedge pclk) disable iff (!presetn)
    (pending != '0) |=> irq); // R5
  AST_IRQ_FALL: assert property (@(posedge pclk) disable iff (!presetn)
    (pending == '0) |=> !irq); // R5
endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top #(
  parameter int NUM_CH    = 3,
  parameter int DATA_W    = mbx_pkg::MBX_DATA_W,
  parameter int ADDR_W    = 12,
  parameter int WIN_BITS  = 5,
  parameter int SECURE_CH = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [2:0]        pprot,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH*DATA_W-1:0] pend_flat;
  logic [NUM_CH-1:0]        set_en, clr_en;

  assign pready = 1'b1;

  mbx_apb_decode #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .WIN_BITS(WIN_BITS), .SECURE_CH(SECURE_CH)
  ) i_decode (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pprot(pprot), .pend_flat(pend_flat),
    .set_en(set_en), .clr_en(clr_en), .rdata(prdata), .slverr(pslverr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mbx_channel #(.DATA_W(DATA_W)) i_chan (
      .pclk(pclk), .presetn(presetn), .set_en(set_en[c]), .clr_en(clr_en[c]),
      .wdata(pwdata), .pending(pend_flat[c*DATA_W +: DATA_W]), .irq(irq[c])
    );
  end

  AST_NS_WRITE_IGNORED: assert property (@(posedge pclk) disable iff (!presetn)
    (pslverr && pwrite) |=> $stable(pend_flat[SECURE_CH*DATA_W +: DATA_W])); // R7
  AST_READY_HIGH: assert property (@(posedge pclk) disable iff (!presetn)
    pready); // R10
  AST_ONE_CHANNEL: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0(set_en | clr_en)); // R6
endmodule

// File: tb/test_mbx_doorbell_top.sv
module test_mbx_doorbell_top;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [2:0]  pprot = 3'b000;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] SEC = 3'b000;
  localparam logic [2:0] NSEC = 3'b010;

  always #10 pclk = ~pclk;

  mbx_doorbell_top i_mbx_doorbell_top (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pprot(pprot),
    .prdata(prdata), .pready(pready), .pslverr(pslverr), .irq(irq)
  );

  function automatic logic [11:0] base(input int ch);
    return 12'(ch * 32);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One APB transfer; err and rd captured in the access phase before the completing edge.
  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [2:0] prot, output logic [31:0] rd, output logic err);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pprot = prot;
    @(negedge pclk);
    penable = 1'b1;
    #2;
    rd = prdata; err = pslverr;
    check("R10 pready", {31'b0, pready}, 32'd1);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] prot,
                    output logic err);
    logic [31:0] dummy;
    xfer(1'b1, a, d, prot, dummy, err);
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] prot,
                    output logic [31:0] v, output logic err);
    xfer(1'b0, a, 32'h0, prot, v, err);
  endtask

  task automatic test_reset();
    logic [31:0] v; logic e;
    check("R1 irq", {29'b0, irq}, 32'd0);
    check("R1 pslverr", {31'b0, pslverr}, 32'd0);
    for (int c = 0; c < 3; c++) begin
      rd(base(c), SEC, v, e);
      check("R1 status", v, 32'd0);
    end
  endtask

  task automatic test_set_clear();
    logic [31:0] v; logic e;
    wr(base(0) + 12'h08, 32'h0000_00F1, SEC, e);
    rd(base(0), SEC, v, e);
    check("R2 set", v, 32'h0000_00F1);
    wr(base(0) + 12'h08, 32'h8000_0000, SEC, e);
    rd(base(0), SEC, v, e);
    check("R2 zero bits keep", v, 32'h8000_00F1);
    check("R5 irq high", {29'b0, irq}, 32'd1);
    wr(base(0) + 12'h10, 32'h0000_0031, SEC, e);
    rd(base(0), SEC, v, e);
    check("R3 clear", v, 32'h8000_00C0);
    check("R4 read after write", v & 32'hFFFF_FFFF, 32'h8000_00C0);
    wr(base(0) + 12'h10, 32'hFFFF_FFFF, SEC, e);
    @(negedge pclk);
    check("R5 irq low", {29'b0, irq}, 32'd0);
    rd(base(0), SEC, v, e);
    check("R3 all clear", v, 32'd0);
  endtask

  task automatic test_irq_timing();
    logic e;
    // Write completes at the edge after penable; irq follows one edge later.
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = base(1) + 12'h08; pwdata = 32'h10; pprot = SEC;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    check("R5 irq not yet", {29'b0, irq}, 32'd0);
    @(negedge pclk);
    check("R5 irq one cycle later", {29'b0, irq}, 32'd2);
    wr(base(1) + 12'h10, 32'h10, SEC, e);
    @(negedge pclk);
    check("R5 irq drop", {29'b0, irq}, 32'd0);
  endtask

  task automatic test_independence();
    logic [31:0] v; logic e;
    wr(base(1) + 12'h08, 32'hA5A5_0000, SEC, e);
    rd(base(0), SEC, v, e);
    check("R6 ch0 untouched", v, 32'd0);
    rd(base(2), SEC, v, e);
    check("R6 ch2 untouched", v, 32'd0);
    rd(base(1), SEC, v, e);
    check("R6 ch1 set", v, 32'hA5A5_0000);
    check("R6 only irq1", {29'b0, irq}, 32'd2);
    wr(base(1) + 12'h10, 32'hFFFF_FFFF, SEC, e);
    @(negedge pclk);
  endtask

  task automatic test_secure();
    logic [31:0] v; logic e;
    wr(base(2) + 12'h08, 32'h0000_0003, SEC, e);
    check("R8 secure write ok", {31'b0, e}, 32'd0);
    rd(base(2), SEC, v, e);
    check("R8 secure read", v, 32'h3);
    check("R8 no error", {31'b0, e}, 32'd0);
    check("R8 irq2", {29'b0, irq}, 32'd4);
    rd(base(2), NSEC, v, e);
    check("R7 ns read zero", v, 32'd0);
    check("R7 ns read error", {31'b0, e}, 32'd1);
    wr(base(2) + 12'h10, 32'hFFFF_FFFF, NSEC, e);
    check("R7 ns write error", {31'b0, e}, 32'd1);
    @(negedge pclk);
    check("R7 irq kept", {29'b0, irq}, 32'd4);
    wr(base(2) + 12'h08, 32'hF000_0000, NSEC, e);
    rd(base(2), SEC, v, e);
    check("R7 ns writes ignored", v, 32'h3);
    wr(base(0) + 12'h08, 32'h1, NSEC, e);
    check("R7 ns ch0 no error", {31'b0, e}, 32'd0);
    rd(base(0), NSEC, v, e);
    check("R7 ns ch0 allowed", v, 32'h1);
    wr(base(0) + 12'h10, 32'h1, SEC, e);
    wr(base(2) + 12'h10, 32'h3, SEC, e);
    @(negedge pclk);
    check("R8 all irq low", {29'b0, irq}, 32'd0);
  endtask

  task automatic test_unmapped();
    logic [31:0] v; logic e;
    wr(base(1) + 12'h08, 32'h0000_0404, SEC, e);
    rd(base(1) + 12'h08, SEC, v, e);
    check("R9 set reads zero", v, 32'd0);
    rd(base(1) + 12'h10, SEC, v, e);
    check("R9 clear reads zero", v, 32'd0);
    rd(12'h300, SEC, v, e);
    check("R9 unmapped read zero", v, 32'd0);
    check("R9 unmapped no error", {31'b0, e}, 32'd0);
    wr(base(1), 32'hFFFF_FFFF, SEC, e);
    wr(base(1) + 12'h04, 32'hFFFF_FFFF, SEC, e);
    wr(base(1) + 12'h0C, 32'hFFFF_FFFF, SEC, e);
    wr(12'h060, 32'hFFFF_FFFF, SEC, e);
    rd(base(1), SEC, v, e);
    check("R9 stray writes ignored", v, 32'h0000_0404);
    rd(base(0), SEC, v, e);
    check("R9 ch0 unaffected", v, 32'd0);
    wr(base(1) + 12'h10, 32'h0000_0404, SEC, e);
  endtask

  initial begin
    #35 presetn = 1'b1;
    test_reset();
    test_set_clear();
    test_irq_timing();
    test_independence();
    test_secure();
    test_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule